// File: doc/BRIEF.md
# Fracturable Eight-Input Lookup Element

This block is the combinational core of a logic slice. It holds two lookup halves, each backed by its own 64-bit truth table, and eight single-bit data inputs named a, b, c0, c1, d0, d1, e and f. Inputs a and b and input e reach both halves. Inputs c0 and d0 reach only half 0, and c1 and d1 reach only half 1. A static two-bit mode field decides how the halves are addressed and combined. They can form one full 6-input function, two 5-input functions, one restricted 8-input function, or two 3-input functions.

Beside the lookup results, the block has two packed-register data paths. Through them, inputs a and b skip the tables and go straight on to a neighbouring register. A two-bit pack request enables these paths. In the single 6-input mode, a and b are both consumed by the table, so packing is not allowed there. A request for it raises a configuration error, and both paths are held low. The configuration (table mask, mode, pack request) is expected to be static. All outputs follow the inputs with no clock.

Top module: `frac_lut8`

## Requirements
- R1: With mode 0 (single 6-input), out_y0 equals cfg_mask bit {f,e,d0,c0,b,a} (a is the least significant index bit, range 0..63), and out_y1 is 0.
- R2: With mode 1 (dual 5-input), out_y0 equals cfg_mask bit {e,d0,c0,b,a}, and out_y1 equals cfg_mask bit 64 + {e,d1,c1,b,a}.
- R3: With mode 2 (extended 8-input), out_y0 equals cfg_mask bit 64 + {e,d1,c1,b,a} when f is 1, and cfg_mask bit {e,d0,c0,b,a} when f is 0. out_y1 is 0.
- R4: With mode 3 (dual 3-input), out_y0 equals cfg_mask bit {d0,c0,e} and out_y1 equals cfg_mask bit 64 + {d1,c1,f}. Inputs a and b have no effect on either result.
- R5: In modes 1, 2 and 3, out_q0 equals a when cfg_pack bit 0 is set and is 0 otherwise. out_q1 equals b when cfg_pack bit 1 is set and is 0 otherwise.
- R6: With mode 0, any set cfg_pack bit drives cfg_err to 1 and forces out_q0 and out_q1 to 0. In every other case cfg_err is 0.
- R7: With mode 1, inputs c1 and d1 have no effect on out_y0, and inputs c0 and d0 have no effect on out_y1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_mask | input | 128 | Truth tables: bits 63..0 for half 0, bits 127..64 for half 1 |
| cfg_mode | input | 2 | 0 single 6-input, 1 dual 5-input, 2 extended 8-input, 3 dual 3-input |
| cfg_pack | input | 2 | Bit 0 enables packed path of a, bit 1 enables packed path of b |
| in_a | input | 1 | Shared data input a |
| in_b | input | 1 | Shared data input b |
| in_c0 | input | 1 | Half 0 data input c0 |
| in_c1 | input | 1 | Half 1 data input c1 |
| in_d0 | input | 1 | Half 0 data input d0 |
| in_d1 | input | 1 | Half 1 data input d1 |
| in_e | input | 1 | Data input e |
| in_f | input | 1 | Data input f |
| out_y0 | output | 1 | Primary lookup result |
| out_y1 | output | 1 | Secondary lookup result |
| out_q0 | output | 1 | Packed-register data path carrying a |
| out_q1 | output | 1 | Packed-register data path carrying b |
| cfg_err | output | 1 | Illegal packing request for the selected mode |

## Verification
The block holds no state, so a fault in index building or result steering shows at out_y0 or out_y1 in the same cycle the bad input is applied. It shows only for input and mask patterns that hit the wrong table bit, which is why each mode gets many random masks and vectors. A wrong pack gating shows at once as a data path that copies a or b when it should be low, or the reverse, or as a cfg_err value that does not fit the mode. Sweeps of the private inputs in dual 5-input mode expose any leak from one half into the other.

// File: rtl/frac_lut8_pkg.sv
package frac_lut8_pkg;
  typedef enum logic [1:0] {
    MODE_SIX   = 2'd0,
    MODE_DUAL5 = 2'd1,
    MODE_EXT8  = 2'd2,
    MODE_DUAL3 = 2'd3
  } lut_mode_e;
endpackage

// File: rtl/frac_lut_half.sv
module frac_lut_half #(
  parameter int HALF_IN = 6
) (
  input  logic [(2**HALF_IN)-1:0] table_bits,
  input  logic [HALF_IN-1:0]      sel,
  output logic                    bit_out
);
  always_comb begin
    bit_out = table_bits[sel];
  end
endmodule

// File: rtl/frac_lut_index.sv
module frac_lut_index
  import frac_lut8_pkg::*;
#(
  parameter int HALF_IN = 6
) (
  input  lut_mode_e          mode,
  input  logic               a,
  input  logic               b,
  input  logic               c0,
  input  logic               c1,
  input  logic               d0,
  input  logic               d1,
  input  logic               e,
  input  logic               f,
  output logic [HALF_IN-1:0] idx0,
  output logic [HALF_IN-1:0] idx1
);
  // Half 0 addressing
  always_comb begin
    unique case (mode)
      MODE_SIX:   idx0 = HALF_IN'({f, e, d0, c0, b, a});
      MODE_DUAL3: idx0 = HALF_IN'({d0, c0, e});
      default:    idx0 = HALF_IN'({e, d0, c0, b, a});
    endcase
  end

  // Half 1 addressing (unused in single mode)
  always_comb begin
    unique case (mode)
      MODE_DUAL3: idx1 = HALF_IN'({d1, c1, f});
      default:    idx1 = HALF_IN'({e, d1, c1, b, a});
    endcase
  end
endmodule

// File: rtl/frac_lut_outsel.sv
module frac_lut_outsel
  import frac_lut8_pkg::*;
(
  input  lut_mode_e mode,
  input  logic      f,
  input  logic      r0,
  input  logic      r1,
  output logic      y0,
  output logic      y1
);
  always_comb begin
    unique case (mode)
      MODE_SIX: begin
        y0 = r0;
        y1 = 1'b0;
      end
      MODE_EXT8: begin
        y0 = f ? r1 : r0;
        y1 = 1'b0;
      end
      default: begin
        y0 = r0;
        y1 = r1;
      end
    endcase
  end

  always_comb begin
    if (!$isunknown({mode, y1})) begin
      if (mode == MODE_SIX || mode == MODE_EXT8) begin
        p_y1_quiet_r1: assert (y1 == 1'b0)
          else $error("y1 active in single-result mode");
      end
    end
    if (!$isunknown({mode, y0, r0, r1})) begin
      if (mode == MODE_EXT8) begin
        p_ext_from_half_r3: assert (y0 == r0 || y0 == r1)
          else $error("extended result not from a half");
      end
    end
  end
endmodule

// File: rtl/frac_lut_pack.sv
module frac_lut_pack
  import frac_lut8_pkg::*;
#(
  parameter int PACK_N = 2
) (
  input  lut_mode_e         mode,
  input  logic [PACK_N-1:0] pack_en,
  input  logic [PACK_N-1:0] src,
  output logic [PACK_N-1:0] q,
  output logic              err
);
  always_comb begin
    err = (mode == MODE_SIX) && (|pack_en);
  end

  for (genvar p = 0; p < PACK_N; p++) begin : g_path
    always_comb begin
      q[p] = (mode != MODE_SIX) && pack_en[p] && src[p];
    end
  end

  always_comb begin
    if (!$isunknown({mode, err, q})) begin
      p_err_six_only_r6: assert (!err || mode == MODE_SIX)
        else $error("error flag outside single mode");
      if (err) begin
        p_no_pack_on_err_r6: assert (q == '0)
          else $error("packed path active with error");
      end
    end
  end
endmodule

// File: rtl/frac_lut8.sv
module frac_lut8
  import frac_lut8_pkg::*;
#(
  parameter int HALF_IN = 6
) (
  input  logic [2*(2**HALF_IN)-1:0] cfg_mask,
  input  logic [1:0]                cfg_mode,
  input  logic [1:0]                cfg_pack,
  input  logic                      in_a,
  input  logic                      in_b,
  input  logic                      in_c0,
  input  logic                      in_c1,
  input  logic                      in_d0,
  input  logic                      in_d1,
  input  logic                      in_e,
  input  logic                      in_f,
  output logic                      out_y0,
  output logic                      out_y1,
  output logic                      out_q0,
  output logic                      out_q1,
  output logic                      cfg_err
);
  localparam int TW     = 2**HALF_IN;
  localparam int HALVES = 2;

  lut_mode_e          mode;
  logic [HALF_IN-1:0] idx [HALVES];
  logic [HALVES-1:0]  res;
  logic [1:0]         qv;

  always_comb begin
    mode = lut_mode_e'(cfg_mode);
  end

  frac_lut_index #(.HALF_IN(HALF_IN)) u_index (
    .mode (mode),
    .a    (in_a),
    .b    (in_b),
    .c0   (in_c0),
    .c1   (in_c1),
    .d0   (in_d0),
    .d1   (in_d1),
    .e    (in_e),
    .f    (in_f),
    .idx0 (idx[0]),
    .idx1 (idx[1])
  );

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    frac_lut_half #(.HALF_IN(HALF_IN)) u_half (
      .table_bits (cfg_mask[h*TW +: TW]),
      .sel        (idx[h]),
      .bit_out    (res[h])
    );
  end

  frac_lut_outsel u_outsel (
    .mode (mode),
    .f    (in_f),
    .r0   (res[0]),
    .r1   (res[1]),
    .y0   (out_y0),
    .y1   (out_y1)
  );

  frac_lut_pack #(.PACK_N(2)) u_pack (
    .mode    (mode),
    .pack_en (cfg_pack),
    .src     ({in_b, in_a}),
    .q       (qv),
    .err     (cfg_err)
  );

  always_comb begin
    out_q0 = qv[0];
    out_q1 = qv[1];
  end

  always_comb begin
    if (!$isunknown({cfg_mode, cfg_pack, in_a, in_b, out_q0, out_q1})) begin
      if (cfg_mode != 2'd0 && cfg_pack[0]) begin
        p_pack_a_r5: assert (out_q0 == in_a)
          else $error("packed path 0 does not carry a");
      end
      if (cfg_mode != 2'd0 && cfg_pack[1]) begin
        p_pack_b_r5: assert (out_q1 == in_b)
          else $error("packed path 1 does not carry b");
      end
    end
  end
endmodule

// File: tb/frac_lut8_test.sv
module frac_lut8_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [127:0] cfg_mask;
  logic [1:0]   cfg_mode, cfg_pack;
  logic in_a, in_b, in_c0, in_c1, in_d0, in_d1, in_e, in_f;
  logic out_y0, out_y1, out_q0, out_q1, cfg_err;

  frac_lut8 uut (
    .cfg_mask (cfg_mask), .cfg_mode (cfg_mode), .cfg_pack (cfg_pack),
    .in_a (in_a), .in_b (in_b), .in_c0 (in_c0), .in_c1 (in_c1),
    .in_d0 (in_d0), .in_d1 (in_d1), .in_e (in_e), .in_f (in_f),
    .out_y0 (out_y0), .out_y1 (out_y1), .out_q0 (out_q0), .out_q1 (out_q1),
    .cfg_err (cfg_err)
  );

  typedef struct {
    logic  y0, y1, q0, q1, err;
    string ytag;
    string qtag;
  } item_t;

  item_t scb[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  // Reference model written from the requirements
  task automatic push_expected(input string ytag_ovr);
    item_t it;
    logic [7:0] lo0, lo1;
    lo0 = {3'b0, in_e, in_d0, in_c0, in_b, in_a};
    lo1 = {3'b0, in_e, in_d1, in_c1, in_b, in_a};
    it.y1 = 1'b0;
    case (cfg_mode)
      2'd0: begin // R1
        it.y0 = cfg_mask[{2'b0, in_f, in_e, in_d0, in_c0, in_b, in_a}];
        it.ytag = "R1";
      end
      2'd1: begin // R2
        it.y0 = cfg_mask[lo0];
        it.y1 = cfg_mask[8'd64 + lo1];
        it.ytag = "R2";
      end
      2'd2: begin // R3
        it.y0 = in_f ? cfg_mask[8'd64 + lo1] : cfg_mask[lo0];
        it.ytag = "R3";
      end
      default: begin // R4
        it.y0 = cfg_mask[{5'b0, in_d0, in_c0, in_e}];
        it.y1 = cfg_mask[8'd64 + {5'b0, in_d1, in_c1, in_f}];
        it.ytag = "R4";
      end
    endcase
    if (ytag_ovr != "") it.ytag = ytag_ovr;
    if (cfg_mode == 2'd0) begin // R6
      it.err = |cfg_pack;
      it.q0 = 1'b0;
      it.q1 = 1'b0;
      it.qtag = "R6";
    end else begin // R5
      it.err = 1'b0;
      it.q0 = cfg_pack[0] & in_a;
      it.q1 = cfg_pack[1] & in_b;
      it.qtag = "R5";
    end
    scb.push_back(it);
  endtask

  task automatic drive(input logic [127:0] m, input logic [1:0] md,
                       input logic [1:0] pk, input logic [7:0] v,
                       input string tag);
    @(posedge clk);
    #1;
    cfg_mask = m; cfg_mode = md; cfg_pack = pk;
    {in_f, in_e, in_d1, in_d0, in_c1, in_c0, in_b, in_a} = v;
    push_expected(tag);
  endtask

  // Monitor: compares at the falling edge
  always @(negedge clk) begin
    if (!done && scb.size() > 0) begin
      item_t it;
      it = scb.pop_front();
      total++;
      if ({out_y0, out_y1} !== {it.y0, it.y1}) begin
        bad++;
        $display("FAIL %s: y1y0 actual=%b%b expected=%b%b", it.ytag,
                 out_y1, out_y0, it.y1, it.y0);
      end
      total++;
      if ({cfg_err, out_q1, out_q0} !== {it.err, it.q1, it.q0}) begin
        bad++;
        $display("FAIL %s: err,q1,q0 actual=%b%b%b expected=%b%b%b", it.qtag,
                 cfg_err, out_q1, out_q0, it.err, it.q1, it.q0);
      end
    end
  end

  function automatic logic [127:0] rmask();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    cfg_mask = '0; cfg_mode = 2'd0; cfg_pack = 2'd0;
    {in_f, in_e, in_d1, in_d0, in_c1, in_c0, in_b, in_a} = 8'h00;
    // Idle: all zero configuration and inputs
    drive(128'h0, 2'd0, 2'd0, 8'h00, "R1");
    // R1: walking one over the full 64-entry table
    for (int i = 0; i < 64; i++) begin
      logic [7:0] v;
      v = {2'b00, i[5], i[4], 1'b0, i[3], 1'b0, i[2]} ;
      v = {2'b00, 6'b0};
      v[0] = i[0]; v[1] = i[1]; v[2] = i[2]; v[4] = i[3]; v[6] = i[4]; v[7] = i[5];
      drive(128'h1 << i, 2'd0, 2'd0, v, "R1");
    end
    // All modes, random masks and inputs, all pack patterns
    for (int md = 0; md < 4; md++) begin
      for (int k = 0; k < 200; k++) begin
        drive(rmask(), md[1:0], 2'($urandom), 8'($urandom), "");
      end
    end
    // R6: every pack request in mode 0
    for (int pk = 0; pk < 4; pk++) begin
      drive(rmask(), 2'd0, pk[1:0], 8'hFF, "R6");
    end
    // R3: f toggling with otherwise fixed inputs
    drive({64'hAAAA_5555_F0F0_0F0F, 64'h5555_AAAA_0F0F_F0F0}, 2'd2, 2'd3, 8'h2D, "R3");
    drive({64'hAAAA_5555_F0F0_0F0F, 64'h5555_AAAA_0F0F_F0F0}, 2'd2, 2'd3, 8'hAD, "R3");
    // R4: a and b swept, y must stay on the table bits
    for (int ab = 0; ab < 4; ab++) begin
      drive({64'h0000_0000_0000_00A5, 64'h0000_0000_0000_005A}, 2'd3, 2'd0,
            {6'b110101, ab[1:0]}, "R4");
    end
    // R7: sweep private inputs of one half in dual mode
    for (int s = 0; s < 16; s++) begin
      logic [7:0] v;
      v = 8'b0110_0001;
      v[3] = s[0]; v[5] = s[1]; // c1, d1
      v[2] = s[2]; v[4] = s[3]; // c0, d0
      drive(128'hDEAD_BEEF_0123_4567_89AB_CDEF_FEDC_BA98, 2'd1, 2'd1, v, "R7");
    end
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule